// File: doc/BRIEF.md
# Multiplexed Button Matrix Reader

This block lets an 8-bit CPU scan 32 active-low push-buttons, organised as four groups of eight, through one 8-bit read location. The CPU first writes a selector byte to a control location. The block keeps the bitwise complement of that byte. In the kept value, the upper nibble names one group when exactly one of its bits is set, and that group's buttons are returned at the read location. Every other upper-nibble pattern returns 0xFF, which reads as "no key pressed".

Raw button lines arrive asynchronously and pass through a two-flop synchroniser before the group multiplexer. Read data is captured into an output register on the clock edge that samples the read request. Both locations decode a four-byte window, so the two lowest address bits are ignored.

Top module: `mxk_button_reader`

## Requirements
- R1: After synchronous reset the kept selector is 0x00, every synchroniser stage holds 0xFF and bus_rdata is 0xFF. Reads return 0xFF until the first selector write.
- R2: A write with bus_addr in 0x0848..0x084B stores the complement of bus_wdata (wdata XOR 0xFF) as the selector. A write to any other address leaves the selector unchanged.
- R3: Kept upper nibble 0x1 (written byte 0xEF) selects group 0 (keys_g0). 0x2 (0xDF) selects group 1. 0x4 (0xBF) selects group 2. 0x8 (0x7F) selects group 3.
- R4: Bits 3..0 of the kept selector take no part in selection. For example, written byte 0xE0 still selects group 0.
- R5: A kept upper nibble with zero bits set or with more than one bit set makes the read return 0xFF.
- R6: A read with bus_addr in 0x0844..0x0847 loads bus_rdata on the sampling edge, so the value can be seen one cycle after the request. Without such a read, including a read at any other address, bus_rdata holds its value.
- R7: A raw button change is first seen by a read that is sampled on the third rising edge after the change. Reads sampled on the first and second edges still return the old value.
- R8: A read sampled on the edge after a selector write uses the new selector.
- R9: Button bits are returned without inversion: a pressed key (0) reads as 0 at its own bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data (selector byte) |
| bus_rdata | output | 8 | Registered read data |
| keys_g0 | input | 8 | Raw active-low buttons, group 0 |
| keys_g1 | input | 8 | Raw active-low buttons, group 1 |
| keys_g2 | input | 8 | Raw active-low buttons, group 2 |
| keys_g3 | input | 8 | Raw active-low buttons, group 3 |

## Verification
Each read result is due on the falling edge after the rising edge that samples the request. A selector write affects a read sampled one edge later. A key change reaches a read only on the third rising edge after it. The bench drives inputs on falling edges and compares bus_rdata with a behavioural model on every falling edge. Directed reads are placed at the exact edges where the old and the new key values differ, so each check sees the latency boundary itself.

// File: rtl/mxk_pkg.sv
package mxk_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic int unsigned ones_in(input logic [BYTE_W-1:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < n; i++) c += int'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/mxk_sync.sv
module mxk_sync #(
  parameter int unsigned W       = 8,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

  if (STAGES == 2) begin : g_lat_chk
    // R7
    sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2)) |-> dout == $past(din, 2));
  end
endmodule

// File: rtl/mxk_bus_decode.sv
module mxk_bus_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WIN_LSB  = 2,
  parameter logic [ADDR_W-1:0] SEL_BASE = 16'h0848,
  parameter logic [ADDR_W-1:0] RD_BASE  = 16'h0844
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              sel_wr,
  output logic              key_rd
);
  localparam int unsigned TAG_W = ADDR_W - WIN_LSB;
  localparam logic [TAG_W-1:0] SEL_TAG = SEL_BASE[ADDR_W-1:WIN_LSB];
  localparam logic [TAG_W-1:0] RD_TAG  = RD_BASE[ADDR_W-1:WIN_LSB];

  logic [TAG_W-1:0] tag;
  assign tag    = addr[ADDR_W-1:WIN_LSB];
  assign sel_wr = wr && (tag == SEL_TAG);
  assign key_rd = rd && (tag == RD_TAG);
endmodule

// File: rtl/mxk_sel_reg.sv
module mxk_sel_reg
  import mxk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  byte_t wdata,
  output byte_t sel_q
);
  always_ff @(posedge clk) begin
    if (rst)       sel_q <= '0;
    else if (load) sel_q <= ~wdata;
  end

  // R2
  sel_store_inv_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> sel_q == ($past(wdata) ^ 8'hFF));
  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(sel_q));
endmodule

// File: rtl/mxk_group_mux.sv
module mxk_group_mux #(
  parameter int unsigned GROUPS  = 4,
  parameter int unsigned GROUP_W = 8
) (
  input  logic [GROUPS-1:0]         pick,
  input  logic [GROUPS*GROUP_W-1:0] keys,
  output logic [GROUP_W-1:0]        dout
);
  logic [GROUP_W-1:0] term [GROUPS];
  logic [GROUP_W-1:0] merged;
  logic               single;

  for (genvar g = 0; g < GROUPS; g++) begin : g_term
    assign term[g] = pick[g] ? keys[g*GROUP_W +: GROUP_W] : '0;
  end

  always_comb begin
    int unsigned cnt;
    merged = '0;
    cnt    = 0;
    for (int unsigned g = 0; g < GROUPS; g++) begin
      merged |= term[g];
      cnt    += int'(pick[g]);
    end
    single = (cnt == 1);
  end

  assign dout = single ? merged : '1;
endmodule

// File: rtl/mxk_button_reader.sv
module mxk_button_reader
  import mxk_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned WIN_LSB     = 2,
  parameter logic [ADDR_W-1:0] SEL_BASE = 16'h0848,
  parameter logic [ADDR_W-1:0] RD_BASE  = 16'h0844,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEL_LSB     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        keys_g0,
  input  logic [7:0]        keys_g1,
  input  logic [7:0]        keys_g2,
  input  logic [7:0]        keys_g3
);
  localparam int unsigned GROUPS  = 4;
  localparam int unsigned GROUP_W = BYTE_W;
  localparam int unsigned KEYS_W  = GROUPS * GROUP_W;

  logic              sel_wr, key_rd;
  byte_t             sel_q;
  logic [KEYS_W-1:0] keys_raw, keys_s;
  logic [GROUP_W-1:0] mux_out;

  assign keys_raw = {keys_g3, keys_g2, keys_g1, keys_g0};

  mxk_bus_decode #(
    .ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .SEL_BASE(SEL_BASE), .RD_BASE(RD_BASE)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .sel_wr(sel_wr), .key_rd(key_rd)
  );

  mxk_sel_reg u_sel (
    .clk(clk), .rst(rst), .load(sel_wr), .wdata(bus_wdata), .sel_q(sel_q)
  );

  mxk_sync #(.W(KEYS_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .din(keys_raw), .dout(keys_s)
  );

  mxk_group_mux #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_mux (
    .pick(sel_q[SEL_LSB +: GROUPS]), .keys(keys_s), .dout(mux_out)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '1;
    else if (key_rd) bus_rdata <= mux_out;
  end

  // R1
  rst_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> bus_rdata == 8'hFF);
  // R5
  bad_pick_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (key_rd && ones_in(sel_q >> SEL_LSB, GROUPS) != 1) |=> bus_rdata == 8'hFF);
  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !key_rd |=> $stable(bus_rdata));
  // R3
  pick_g0_chk: assert property (@(posedge clk) disable iff (rst)
    (key_rd && sel_q[SEL_LSB +: GROUPS] == 4'h1) |=> bus_rdata == $past(keys_s[GROUP_W-1:0]));
endmodule

// File: tb/mxk_button_reader_tb.sv
module mxk_button_reader_tb;
  logic        clk = 0;
  logic        rst;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [7:0]  keys_g0, keys_g1, keys_g2, keys_g3;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mxk_button_reader u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .keys_g0(keys_g0), .keys_g1(keys_g1), .keys_g2(keys_g2), .keys_g3(keys_g3)
  );

  // Behavioural reference model
  logic [7:0]  m_sel, m_rd;
  logic [31:0] m_s1, m_s2;

  function automatic logic [7:0] pick(input logic [7:0] sel, input logic [31:0] k);
    case (sel[7:4])
      4'h1: return k[7:0];
      4'h2: return k[15:8];
      4'h4: return k[23:16];
      4'h8: return k[31:24];
      default: return 8'hFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sel = 8'h00; m_s1 = '1; m_s2 = '1; m_rd = 8'hFF;
    end else begin
      if (bus_rd && bus_addr[15:2] == 14'h0211) m_rd = pick(m_sel, m_s2);
      if (bus_wr && bus_addr[15:2] == 14'h0212) m_sel = bus_wdata ^ 8'hFF;
      m_s2 = m_s1;
      m_s1 = {keys_g3, keys_g2, keys_g1, keys_g0};
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (!done && !rst) chk("R6 model", bus_rdata, m_rd);

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic set_keys(input logic [7:0] a, b, c, d);
    keys_g0 = a; keys_g1 = b; keys_g2 = c; keys_g3 = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    set_keys(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset rdata", bus_rdata, 8'hFF);
    set_keys(8'hFE, 8'hFD, 8'hFB, 8'hF7);
    repeat (3) @(negedge clk);
    rd(16'h0844);
    chk("R1 read before selector write", bus_rdata, 8'hFF);

    wr(16'h0848, 8'hEF); rd(16'h0845);
    chk("R3 R8 group0", bus_rdata, 8'hFE);
    wr(16'h0849, 8'hDF); rd(16'h0846);
    chk("R3 group1", bus_rdata, 8'hFD);
    wr(16'h084A, 8'hBF); rd(16'h0847);
    chk("R3 group2", bus_rdata, 8'hFB);
    wr(16'h084B, 8'h7F); rd(16'h0844);
    chk("R3 R9 group3", bus_rdata, 8'hF7);

    wr(16'h0848, 8'hE0); rd(16'h0844);
    chk("R4 low nibble ignored", bus_rdata, 8'hFE);
    wr(16'h084C, 8'hDF); rd(16'h0844);
    chk("R2 write outside window ignored", bus_rdata, 8'hFE);

    wr(16'h0848, 8'hFF); rd(16'h0844);
    chk("R5 zero nibble", bus_rdata, 8'hFF);
    wr(16'h0848, 8'hCF); rd(16'h0844);
    chk("R5 two bits", bus_rdata, 8'hFF);
    wr(16'h0848, 8'h0F); rd(16'h0844);
    chk("R5 all bits", bus_rdata, 8'hFF);

    wr(16'h0848, 8'hDF); rd(16'h0844);
    chk("R2 R8 back to group1", bus_rdata, 8'hFD);
    rd(16'h0840);
    chk("R6 read outside window holds", bus_rdata, 8'hFD);
    repeat (2) @(negedge clk);
    chk("R6 idle hold", bus_rdata, 8'hFD);

    keys_g1 = 8'h5A;
    rd(16'h0844);
    chk("R7 edge1 old", bus_rdata, 8'hFD);
    rd(16'h0844);
    chk("R7 edge2 old", bus_rdata, 8'hFD);
    rd(16'h0844);
    chk("R7 edge3 new", bus_rdata, 8'h5A);

    set_keys(8'h00, 8'hA5, 8'h3C, 8'h81);
    repeat (2) @(negedge clk);
    wr(16'h0848, 8'hEF); rd(16'h0844);
    chk("R9 all pressed group0", bus_rdata, 8'h00);
    wr(16'h0848, 8'h7F); rd(16'h0844);
    chk("R9 pattern group3", bus_rdata, 8'h81);

    rst = 1; @(negedge clk); rst = 0;
    chk("R1 second reset", bus_rdata, 8'hFF);
    rd(16'h0844);
    chk("R1 selector cleared", bus_rdata, 8'hFF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule